// File: doc/BRIEF.md
# Cache Watch Engine Allocator

This block lets software change a table entry that may sit in a cache without taking a software lock. It holds a small pool of watch engines. Software claims an engine by reading an allocation register, which returns the engine number. Through that engine's registers it then names the entry and moves the entry's contents. It gives the engine back by reading the engine's spec register. That read also reports whether an outside agent updated the watched entry while the engine was held. When every engine is taken, the allocation read returns a sentinel and software tries again.

The block sits on a simple register bus with one access per cycle. Read data returns on the cycle after the access. A sideband input carries external updates to entries, given as an index and a table selector. The block keeps no backing table and no cache. Each engine holds its own copy of the watched entry's data.

Top module: `cwe_top`

## Requirements
- R1: After reset every engine is free and `bus_rdata` is zero.
- R2: A read of address 0x00 reserves the lowest-numbered free engine. It returns that engine's number in `bus_rdata` on the next cycle, and the engine's index, type, data and conflict state start at zero.
- R3: A read of address 0x00 while all engines are reserved returns 0xFF and changes no engine.
- R4: A read of a reserved engine's spec register (address 0x10 + 2·e) frees the engine, and a later allocation can claim it again.
- R5: Spec register layout: bits [7:0] hold the watched index, bits [9:8] the table type, bit 30 the conflict flag and bit 31 the full flag. Writing bit 30 has no effect.
- R6: Every spec read of a reserved engine returns the full flag (bit 31) as 1.
- R7: Table type codes are 0 for the queue table, 1 for the virtual-processor table and 2 for the group table. A sideband update marks a conflict only when both its table code and its index match the engine's.
- R8: A read of a reserved engine's data register (address 0x11 + 2·e) clears bit 31, the generation-flipped bit, when the type is 0. The bit is cleared in both the returned value and the held value. For other types the data comes back unchanged.
- R9: The conflict flag is set by a matching sideband update while the engine is reserved, and is cleared when the engine is newly reserved. An update in the same cycle as the releasing spec read is not reported and is not carried into the next reservation.
- R10: For an engine that is not reserved, spec and data reads return zero and change nothing, and writes to its registers are ignored.
- R11: Reads of addresses outside 0x00 and the engine register window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| upd_valid | input | 1 | An external update to a table entry happens this cycle |
| upd_index | input | 8 | Index of the updated entry |
| upd_table | input | 2 | Table code of the updated entry |

## Verification
The sideband update can land in the same cycle as a bus access that touches the same engine. The case that matters most is the releasing spec read. The bench drives a matching update together with that read and expects the returned word to show no conflict. It then claims the engine again and expects its conflict flag to be clear. A matching update is also driven with a mismatched table code, and with a spec write that changes the index in the same cycle. The behavioural model compares every result against `bus_rdata` on each cycle.

// File: rtl/cwe_pkg.sv
package cwe_pkg;

    typedef enum logic [1:0] {
        TBL_QUEUE = 2'd0,
        TBL_VPROC = 2'd1,
        TBL_GROUP = 2'd2,
        TBL_SPARE = 2'd3
    } tbl_e;

    localparam logic [7:0] NONE_FREE = 8'hFF;

endpackage

// File: rtl/cwe_alloc.sv
module cwe_alloc #(
    parameter int N_ENG = 4,
    localparam int ENG_W = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic [N_ENG-1:0] busy_i,
    output logic [N_ENG-1:0] grant_o,
    output logic [ENG_W-1:0] grant_num_o,
    output logic             any_free_o
);

    always_comb begin
        grant_o     = '0;
        grant_num_o = '0;
        any_free_o  = 1'b0;
        for (int e = N_ENG - 1; e >= 0; e--) begin
            if (!busy_i[e]) begin
                grant_o     = '0;
                grant_o[e]  = 1'b1;
                grant_num_o = ENG_W'(e);
                any_free_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwe_engine.sv
module cwe_engine
    import cwe_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    localparam int PAD_W = DATA_W - IDX_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim_i,
    input  logic              release_i,
    input  logic              spec_wr_i,
    input  logic              data_wr_i,
    input  logic              data_rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              upd_valid_i,
    input  logic [IDX_W-1:0]  upd_index_i,
    input  tbl_e              upd_table_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] spec_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              busy;
        logic              conf;
        tbl_e              typ;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t st_d, st_q;
    logic hit;

    always_comb begin
        hit  = upd_valid_i && st_q.busy
               && (upd_index_i == st_q.idx) && (upd_table_i == st_q.typ);
        st_d = st_q;
        if (hit) st_d.conf = 1'b1;
        if (spec_wr_i && st_q.busy) begin
            st_d.idx = wdata_i[IDX_W-1:0];
            st_d.typ = tbl_e'(wdata_i[IDX_W+1:IDX_W]);
        end
        if (data_wr_i && st_q.busy) st_d.data = wdata_i;
        if (data_rd_i && st_q.busy && st_q.typ == TBL_QUEUE)
            st_d.data[DATA_W-1] = 1'b0;
        if (release_i && st_q.busy) st_d = '0;
        if (claim_i) begin
            st_d      = '0;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        busy_o = st_q.busy;
        spec_o = '0;
        data_o = '0;
        if (st_q.busy) begin
            spec_o = {1'b1, st_q.conf, {PAD_W{1'b0}}, st_q.typ, st_q.idx};
            data_o = st_q.data;
            if (st_q.typ == TBL_QUEUE) data_o[DATA_W-1] = 1'b0;
        end
    end

endmodule

// File: rtl/cwe_top.sv
module cwe_top
    import cwe_pkg::*;
#(
    parameter int N_ENG  = 4,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ENG_BASE = 8'h10,
    localparam int ENG_W = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_index,
    input  logic [1:0]        upd_table
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic [N_ENG-1:0]  busy_vec;
    logic [N_ENG-1:0]  grant;
    logic [N_ENG-1:0]  eng_hit;
    logic [ENG_W-1:0]  grant_num;
    logic              any_free;
    logic              asg_rd;
    logic              in_win;
    logic              is_data;
    logic [ADDR_W-1:0] off;
    logic [DATA_W-1:0] spec_w [N_ENG];
    logic [DATA_W-1:0] data_w [N_ENG];

    always_comb begin
        off     = bus_addr - ENG_BASE;
        in_win  = (bus_addr >= ENG_BASE) && (off < ADDR_W'(2 * N_ENG));
        is_data = off[0];
        asg_rd  = bus_sel && !bus_wr && (bus_addr == '0);
    end

    cwe_alloc #(.N_ENG(N_ENG)) u_alloc (
        .busy_i      (busy_vec),
        .grant_o     (grant),
        .grant_num_o (grant_num),
        .any_free_o  (any_free)
    );

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        assign eng_hit[e] = bus_sel && in_win && (off[ADDR_W-1:1] == (ADDR_W-1)'(e));

        cwe_engine #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_eng (
            .clk         (clk),
            .rst_n       (rst_n),
            .claim_i     (asg_rd && grant[e]),
            .release_i   (eng_hit[e] && !bus_wr && !is_data),
            .spec_wr_i   (eng_hit[e] && bus_wr && !is_data),
            .data_wr_i   (eng_hit[e] && bus_wr && is_data),
            .data_rd_i   (eng_hit[e] && !bus_wr && is_data),
            .wdata_i     (bus_wdata),
            .upd_valid_i (upd_valid),
            .upd_index_i (upd_index),
            .upd_table_i (tbl_e'(upd_table)),
            .busy_o      (busy_vec[e]),
            .spec_o      (spec_w[e]),
            .data_o      (data_w[e])
        );
    end

    always_comb begin
        top_d.rdata = '0;
        if (asg_rd)
            top_d.rdata = any_free ? DATA_W'(grant_num) : DATA_W'(NONE_FREE);
        for (int e = 0; e < N_ENG; e++) begin
            if (eng_hit[e] && !bus_wr)
                top_d.rdata = is_data ? data_w[e] : spec_w[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;

endmodule

// File: rtl/cwe_checker.sv
module cwe_checker #(
    parameter int N_ENG  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ENG_BASE = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_ENG-1:0]  busy_vec
);

    logic asg_rd;
    assign asg_rd = bus_sel && !bus_wr && (bus_addr == '0);

    a_r3_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        asg_rd && (&busy_vec) |=> (bus_rdata == DATA_W'(8'hFF)) && $stable(busy_vec));

    a_r2_claim_one: assert property (@(posedge clk) disable iff (!rst_n)
        asg_rd && !(&busy_vec) |=>
            ($countones(busy_vec) == $countones($past(busy_vec)) + 1)
            && (bus_rdata < DATA_W'(N_ENG)));

    for (genvar e = 0; e < N_ENG; e++) begin : g_chk
        localparam logic [ADDR_W-1:0] SPEC_A = ENG_BASE + ADDR_W'(2 * e);
        localparam logic [ADDR_W-1:0] DATA_A = ENG_BASE + ADDR_W'(2 * e + 1);

        a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
            bus_sel && !bus_wr && bus_addr == SPEC_A && busy_vec[e] |=> !busy_vec[e]);

        a_r6_full_set: assert property (@(posedge clk) disable iff (!rst_n)
            bus_sel && !bus_wr && bus_addr == SPEC_A && busy_vec[e] |=> bus_rdata[DATA_W-1]);

        a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_sel && !bus_wr && (bus_addr == SPEC_A || bus_addr == DATA_A) && !busy_vec[e]
            |=> (bus_rdata == '0) && $stable(busy_vec));
    end

endmodule

bind cwe_top cwe_checker #(
    .N_ENG(N_ENG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENG_BASE(ENG_BASE)
) u_cwe_checker (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .busy_vec(busy_vec)
);

// File: tb/test_cwe_top.sv
`timescale 1ns/1ps
module test_cwe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_valid = 1'b0;
    logic [7:0]  upd_index = '0;
    logic [1:0]  upd_table = '0;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    cwe_top i_cwe_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_table(upd_table)
    );

    // behavioural reference model
    bit          m_busy [4];
    bit          m_conf [4];
    logic [1:0]  m_typ  [4];
    logic [7:0]  m_idx  [4];
    logic [31:0] m_data [4];
    logic [31:0] m_exp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < 4; e++) begin
                m_busy[e] = 0; m_conf[e] = 0; m_typ[e] = 0; m_idx[e] = 0; m_data[e] = 0;
            end
            m_exp = 0;
        end else begin
            int eng;
            bit hit_eng, dreg;
            eng = (int'(bus_addr) - 16) / 2;
            dreg = bus_addr[0];
            hit_eng = bus_sel && bus_addr >= 8'h10 && bus_addr < 8'h18;
            m_exp = 0;
            if (bus_sel && !bus_wr && bus_addr == 8'h00) begin
                int fr;
                fr = -1;
                for (int e = 3; e >= 0; e--) if (!m_busy[e]) fr = e;
                m_exp = (fr < 0) ? 32'hFF : 32'(fr);
            end else if (hit_eng && !bus_wr && m_busy[eng]) begin
                if (dreg) m_exp = (m_typ[eng] == 0) ? (m_data[eng] & 32'h7FFF_FFFF) : m_data[eng];
                else      m_exp = {1'b1, m_conf[eng], 20'd0, m_typ[eng], m_idx[eng]};
            end
            if (upd_valid)
                for (int e = 0; e < 4; e++)
                    if (m_busy[e] && m_idx[e] == upd_index && m_typ[e] == upd_table) m_conf[e] = 1;
            if (bus_sel && !bus_wr && bus_addr == 8'h00 && m_exp != 32'hFF) begin
                int g;
                g = int'(m_exp);
                m_busy[g] = 1; m_conf[g] = 0; m_typ[g] = 0; m_idx[g] = 0; m_data[g] = 0;
            end else if (hit_eng && m_busy[eng]) begin
                if (!bus_wr && !dreg) begin
                    m_busy[eng] = 0; m_conf[eng] = 0; m_typ[eng] = 0; m_idx[eng] = 0; m_data[eng] = 0;
                end else if (!bus_wr && dreg) begin
                    if (m_typ[eng] == 0) m_data[eng][31] = 1'b0;
                end else if (bus_wr && !dreg) begin
                    m_idx[eng] = bus_wdata[7:0]; m_typ[eng] = bus_wdata[9:8];
                end else begin
                    m_data[eng] = bus_wdata;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(posedge clk) begin
        #2;
        if (cmp_en && !done) check(bus_rdata === m_exp, cur_tag, bus_rdata, m_exp);
    end

    task automatic op(input bit wr, input logic [7:0] a, input logic [31:0] w,
                      input bit uv, input logic [7:0] ui, input logic [1:0] ut,
                      input bit chk, input logic [31:0] exp, input string tag);
        cur_tag   = tag;
        bus_sel   = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = w;
        upd_valid = uv;   upd_index = ui; upd_table = ut;
        @(posedge clk); #2;
        if (chk) check(bus_rdata === exp, tag, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; upd_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        op(1'b0, a, '0, 1'b0, '0, '0, 1'b1, exp, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] w, input string tag);
        op(1'b1, a, w, 1'b0, '0, '0, 1'b0, '0, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        #1 check(bus_rdata === 32'h0, "R1", bus_rdata, 32'h0);
        @(negedge clk);

        // R2: lowest free first; R3: exhaustion sentinel
        rd(8'h00, 32'd0, "R2");
        rd(8'h00, 32'd1, "R2");
        rd(8'h00, 32'd2, "R2");
        rd(8'h00, 32'd3, "R2");
        rd(8'h00, 32'hFF, "R3");
        rd(8'h00, 32'hFF, "R3");

        // R8: queue type clears generation-flipped bit
        wr(8'h12, 32'h0000_005A, "R5");
        wr(8'h13, 32'h8000_1234, "R8");
        rd(8'h13, 32'h0000_1234, "R8");
        rd(8'h13, 32'h0000_1234, "R8");
        wr(8'h14, 32'h0000_015A, "R7");
        wr(8'h15, 32'h8000_0001, "R8");
        rd(8'h15, 32'h8000_0001, "R8");

        // R7: update hits only the engine with the matching table code
        op(1'b0, 8'h30, '0, 1'b1, 8'h5A, 2'd0, 1'b1, 32'h0, "R11");
        rd(8'h14, 32'h8000_015A, "R7");
        rd(8'h12, 32'hC000_005A, "R9");
        rd(8'h12, 32'h0, "R10");

        // R9: flag cleared on new reservation; R5 conflict bit not writable
        rd(8'h00, 32'd1, "R4");
        rd(8'h12, 32'h8000_0000, "R9");
        rd(8'h00, 32'd1, "R4");
        wr(8'h12, 32'h4000_0033, "R5");
        // R9: matching update in the same cycle as the releasing read
        op(1'b0, 8'h12, '0, 1'b1, 8'h33, 2'd0, 1'b1, 32'h8000_0033, "R9");
        rd(8'h00, 32'd1, "R9");
        rd(8'h12, 32'h8000_0000, "R9");

        // R7: update in the same cycle as a spec write matches the old index
        rd(8'h00, 32'd1, "R2");
        wr(8'h12, 32'h0000_0244, "R7");
        op(1'b1, 8'h12, 32'h0000_0277, 1'b1, 8'h44, 2'd2, 1'b0, '0, "R7");
        rd(8'h12, 32'hC000_0277, "R7");

        // R10: unreserved engine ignores writes, reads zero
        wr(8'h15, 32'h0000_1111, "R10");
        wr(8'h14, 32'h0000_0123, "R10");
        rd(8'h15, 32'h0, "R10");
        rd(8'h00, 32'd1, "R2");
        rd(8'h00, 32'd2, "R2");
        rd(8'h15, 32'h0, "R10");
        rd(8'h14, 32'h8000_0000, "R6");
        rd(8'h15, 32'h0, "R10");
        rd(8'h30, 32'h0, "R11");
        rd(8'h16, 32'h8000_0000, "R6");
        rd(8'h00, 32'd2, "R4");
        rd(8'h10, 32'h8000_0000, "R6");
        rd(8'h00, 32'd0, "R2");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule